// File: doc/BRIEF.md
# Pipelined Wishbone Bus Master with Ordered Result Buffer

This block issues read and write requests onto a pipelined-mode Wishbone bus. A requester presents one request at a time on a valid/ready port. The request goes onto the bus in the same cycle it is accepted, so requests can follow each other on consecutive cycles whenever the slave does not stall. The master counts the requests that have been accepted by the slave and not yet answered. Each ACK, ERR or RTY answers the oldest of them and pushes one result into an internal buffer. A consumer drains that buffer in order through a valid/ready result port.

The buffer depth `MAX_PEND` is also the credit limit. A new request is only let onto the bus while the pending requests plus the unread results stay below that depth, so a response always finds a free slot. The `idle_o` output reports that no accepted request is still waiting for its response. Data width, address width and byte-select granularity are parameters; they default to 64, 64 and 8.

Top module: `wb_pipe_master`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, `idle_o` is 1 and `wb_cyc_o`, `wb_stb_o` and `res_valid_o` are 0.
- R2: When a credit is free, `wb_stb_o` equals `req_valid_i`. In the same cycle `wb_adr_o`, `wb_we_o`, `wb_dat_o` and `wb_sel_o` carry the presented request. `req_ready_o` is 1 exactly when a credit is free and `wb_stall_i` is 0.
- R3: While `wb_stall_i` is 1, no request is accepted. A requester that holds its request sees `wb_stb_o` and `wb_adr_o` held until the stall clears.
- R4: Pending requests plus unread results never exceed `MAX_PEND`. When they equal it, `req_ready_o` and `wb_stb_o` are 0.
- R5: `wb_cyc_o` is 1 whenever a request is pending or `wb_stb_o` is 1, and 0 otherwise.
- R6: An `wb_ack_i` with a request pending completes the oldest pending request. On the next cycle the buffer holds a result with error flag 0 and data equal to the `wb_dat_i` sampled with the ACK. The data is meaningful for reads only.
- R7: An `wb_err_i` or `wb_rty_i` with a request pending completes the oldest request the same way, but with error flag 1. If several response inputs are asserted together, this counts as one response with error flag 1.
- R8: `res_valid_o` is 1 exactly when the buffer is not empty. Results leave in the order their responses arrived, one per cycle in which `res_valid_o` and `res_ready_i` are both 1. An unread result stays stable on the result port.
- R9: `idle_o` is 1 exactly when every accepted request has received its response.
- R10: A response input asserted while no request is pending is ignored and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request presented |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Request address |
| req_data_i | input | DATA_W | Write data |
| req_sel_i | input | DATA_W/GRAN | Byte-lane selects |
| res_valid_o | output | 1 | Buffered result available |
| res_ready_i | input | 1 | Consumer takes the head result |
| res_err_o | output | 1 | Head result error flag |
| res_data_o | output | DATA_W | Head result read data |
| idle_o | output | 1 | No request awaiting a response |
| wb_cyc_o | output | 1 | Bus cycle |
| wb_stb_o | output | 1 | Strobe |
| wb_we_o | output | 1 | Write enable |
| wb_adr_o | output | ADDR_W | Address |
| wb_dat_o | output | DATA_W | Write data |
| wb_sel_o | output | DATA_W/GRAN | Byte selects |
| wb_stall_i | input | 1 | Slave stall |
| wb_ack_i | input | 1 | Normal completion |
| wb_err_i | input | 1 | Error completion |
| wb_rty_i | input | 1 | Retry, treated as error |
| wb_dat_i | input | DATA_W | Read data |

## Verification
A wrong pending count shows up at the ports in two ways. `idle_o` becomes wrong in the cycle after the response that should have drained the count. The credit limit is also wrong: with the result port held off, `req_ready_o` goes low one request early or one request late. A wrong buffer pointer or occupancy makes `res_valid_o` or the head result go wrong on the cycle after the push or pop that corrupted it. The reference model is compared every cycle, so each fault is reported within one clock of reaching a port.

// File: rtl/wb_pm_pkg.sv
package wb_pm_pkg;

  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_OK   = 2'd1,
    RSP_FAIL = 2'd2
  } rsp_kind_e;

  function automatic rsp_kind_e classify(input logic ack, input logic err, input logic rty);
    if (err || rty) return RSP_FAIL;
    if (ack)        return RSP_OK;
    return RSP_NONE;
  endfunction

endpackage

// File: rtl/wb_pm_rsp_dec.sv
module wb_pm_rsp_dec
  import wb_pm_pkg::*;
(
  input  logic ack_i,
  input  logic err_i,
  input  logic rty_i,
  input  logic pend_nz_i,
  output logic push_o,
  output logic fail_o
);
  rsp_kind_e kind;

  always_comb begin
    kind   = classify(ack_i, err_i, rty_i);
    // stray responses with nothing outstanding are dropped
    push_o = pend_nz_i && (kind != RSP_NONE);
    fail_o = (kind == RSP_FAIL);
  end
endmodule

// File: rtl/wb_pm_credit.sv
module wb_pm_credit #(
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned CNT_W = $clog2(MAX_PEND + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic             resp_i,
  input  logic [CNT_W-1:0] buf_cnt_i,
  output logic [CNT_W-1:0] pend_cnt_o,
  output logic             space_o
);
  logic [CNT_W:0] used;

  assign used    = {1'b0, pend_cnt_o} + {1'b0, buf_cnt_i};
  assign space_o = used < (CNT_W + 1)'(MAX_PEND);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_cnt_o <= '0;
    end else begin
      case ({issue_i, resp_i})
        2'b10:   pend_cnt_o <= pend_cnt_o + 1'b1;
        2'b01:   pend_cnt_o <= pend_cnt_o - 1'b1;
        default: pend_cnt_o <= pend_cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/wb_pm_fifo.sv
module wb_pm_fifo #(
  parameter int unsigned WIDTH = 65,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic             valid_o,
  output logic [WIDTH-1:0] data_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = (cnt_o != '0);
  assign data_o  = mem[rd_ptr];

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wr_ptr] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end
endmodule

// File: rtl/wb_pipe_master.sv
module wb_pipe_master #(
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned GRAN     = 8,
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned SEL_W   = DATA_W / GRAN,
  localparam int unsigned CNT_W   = $clog2(MAX_PEND + 1),
  localparam int unsigned ENT_W   = DATA_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_we_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_data_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_err_o,
  output logic [DATA_W-1:0] res_data_o,
  output logic              idle_o,
  output logic              wb_cyc_o,
  output logic              wb_stb_o,
  output logic              wb_we_o,
  output logic [ADDR_W-1:0] wb_adr_o,
  output logic [DATA_W-1:0] wb_dat_o,
  output logic [SEL_W-1:0]  wb_sel_o,
  input  logic              wb_stall_i,
  input  logic              wb_ack_i,
  input  logic              wb_err_i,
  input  logic              wb_rty_i,
  input  logic [DATA_W-1:0] wb_dat_i
);
  logic             space, issue, rsp_push, rsp_fail;
  logic [CNT_W-1:0] pend_cnt, buf_cnt;
  logic [ENT_W-1:0] head;

  // request goes straight onto the bus; stall back-pressures the requester
  assign wb_stb_o    = req_valid_i && space;
  assign req_ready_o = space && !wb_stall_i;
  assign issue       = wb_stb_o && !wb_stall_i;
  assign wb_we_o     = req_we_i;
  assign wb_adr_o    = req_addr_i;
  assign wb_dat_o    = req_data_i;
  assign wb_sel_o    = req_sel_i;
  assign wb_cyc_o    = wb_stb_o || (pend_cnt != '0);
  assign idle_o      = (pend_cnt == '0);

  wb_pm_rsp_dec u_dec (
    .ack_i     (wb_ack_i),
    .err_i     (wb_err_i),
    .rty_i     (wb_rty_i),
    .pend_nz_i (pend_cnt != '0),
    .push_o    (rsp_push),
    .fail_o    (rsp_fail)
  );

  wb_pm_credit #(.MAX_PEND(MAX_PEND)) u_credit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .issue_i    (issue),
    .resp_i     (rsp_push),
    .buf_cnt_i  (buf_cnt),
    .pend_cnt_o (pend_cnt),
    .space_o    (space)
  );

  wb_pm_fifo #(.WIDTH(ENT_W), .DEPTH(MAX_PEND)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rsp_push),
    .data_i  ({rsp_fail, wb_dat_i}),
    .pop_i   (res_valid_o && res_ready_i),
    .valid_o (res_valid_o),
    .data_o  (head),
    .cnt_o   (buf_cnt)
  );

  assign res_err_o  = head[DATA_W];
  assign res_data_o = head[DATA_W-1:0];
endmodule

// File: rtl/wb_pipe_master_chk.sv
module wb_pipe_master_chk #(
  parameter int unsigned ADDR_W   = 64,
  parameter int unsigned DATA_W   = 64,
  parameter int unsigned MAX_PEND = 8,
  localparam int unsigned CNT_W   = $clog2(MAX_PEND + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_ready_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic [DATA_W-1:0] res_data_o,
  input logic              idle_o,
  input logic              wb_cyc_o,
  input logic              wb_stb_o,
  input logic [ADDR_W-1:0] wb_adr_o,
  input logic              wb_stall_i,
  input logic              wb_ack_i,
  input logic              wb_err_i,
  input logic              wb_rty_i,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic [CNT_W-1:0]  buf_cnt
);
  logic any_rsp;
  assign any_rsp = wb_ack_i || wb_err_i || wb_rty_i;

  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_stb_o && wb_stall_i |=> wb_stb_o && $stable(wb_adr_o));

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, pend_cnt} + {1'b0, buf_cnt}) <= (CNT_W + 1)'(MAX_PEND));

  assert_full_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ({1'b0, pend_cnt} + {1'b0, buf_cnt}) == (CNT_W + 1)'(MAX_PEND) |-> !req_ready_o && !wb_stb_o);

  assert_cyc_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_cnt != '0 |-> wb_cyc_o);

  assert_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o));

  assert_last_rsp_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rsp && pend_cnt == CNT_W'(1) && !(wb_stb_o && !wb_stall_i) |=> idle_o);

  assert_stray_rsp_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_rsp && idle_o && !res_valid_o |=> !res_valid_o);
endmodule

bind wb_pipe_master wb_pipe_master_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_PEND(MAX_PEND)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_data_o  (res_data_o),
  .idle_o      (idle_o),
  .wb_cyc_o    (wb_cyc_o),
  .wb_stb_o    (wb_stb_o),
  .wb_adr_o    (wb_adr_o),
  .wb_stall_i  (wb_stall_i),
  .wb_ack_i    (wb_ack_i),
  .wb_err_i    (wb_err_i),
  .wb_rty_i    (wb_rty_i),
  .pend_cnt    (pend_cnt),
  .buf_cnt     (buf_cnt)
);

// File: tb/wb_pipe_master_bench.sv
module wb_pipe_master_bench;
  localparam int DW = 64, AW = 64, SW = 8, MAXP = 8;
  localparam int WATCHDOG = 100000;

  logic          clk_i = 0, rst_ni = 0;
  logic          req_valid_i = 0, req_we_i = 0, res_ready_i = 0;
  logic [AW-1:0] req_addr_i = '0;
  logic [DW-1:0] req_data_i = '0, wb_dat_i = '0;
  logic [SW-1:0] req_sel_i = '0;
  logic          wb_stall_i = 0, wb_ack_i = 0, wb_err_i = 0, wb_rty_i = 0;
  logic          req_ready_o, res_valid_o, res_err_o, idle_o;
  logic          wb_cyc_o, wb_stb_o, wb_we_o;
  logic [DW-1:0] res_data_o, wb_dat_o;
  logic [AW-1:0] wb_adr_o;
  logic [SW-1:0] wb_sel_o;

  int checks = 0, errors = 0;
  int pend = 0;
  logic [AW-1:0]   slave_q[$];
  logic [DW:0]     res_q[$];
  string           rv_tag = "R8";

  always #4 clk_i = ~clk_i;

  wb_pipe_master #(.DATA_W(DW), .ADDR_W(AW), .GRAN(8), .MAX_PEND(MAXP)) u_wb_pipe_master (.*);

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
    return a ^ 64'hC3A5_5A3C_0F1E_2D4B;
  endfunction

  task automatic run_phase(input int n, input int p_valid, input int p_stall, input int p_rsp,
                           input int p_fail, input int p_ready, input bit stray);
    for (int i = 0; i < n; i++) begin
      bit space, exp_ready, exp_stb, acc, rsp;
      @(negedge clk_i);
      if (!(req_valid_i && !acc_last)) begin
        req_valid_i = ($urandom_range(99) < p_valid);
        req_addr_i  = {$urandom, $urandom};
        req_data_i  = {$urandom, $urandom};
        req_we_i    = $urandom_range(1);
        req_sel_i   = SW'($urandom);
      end
      wb_stall_i = ($urandom_range(99) < p_stall);
      {wb_ack_i, wb_err_i, wb_rty_i} = 3'b000;
      if (slave_q.size() > 0 && $urandom_range(99) < p_rsp) begin
        wb_dat_i = rd_val(slave_q[0]);
        if ($urandom_range(99) < p_fail) begin
          if ($urandom_range(1) == 1) wb_err_i = 1; else wb_rty_i = 1;
        end else wb_ack_i = 1;
      end else if (stray && pend == 0 && $urandom_range(1) == 1) begin
        wb_ack_i = 1;
        wb_dat_i = {$urandom, $urandom};
      end
      res_ready_i = ($urandom_range(99) < p_ready);
      #1;
      space     = (pend + res_q.size()) < MAXP;
      exp_ready = space && !wb_stall_i;
      exp_stb   = req_valid_i && space;
      chk(req_ready_o == exp_ready, (space ? "R3" : "R4"), 128'(req_ready_o), 128'(exp_ready));
      chk(wb_stb_o == exp_stb, (space ? "R2" : "R4"), 128'(wb_stb_o), 128'(exp_stb));
      if (exp_stb)
        chk(wb_adr_o == req_addr_i && wb_dat_o == req_data_i && wb_we_o == req_we_i && wb_sel_o == req_sel_i,
            "R2", 128'(wb_adr_o), 128'(req_addr_i));
      chk(wb_cyc_o == (exp_stb || pend > 0), "R5", 128'(wb_cyc_o), 128'(exp_stb || pend > 0));
      chk(idle_o == (pend == 0), "R9", 128'(idle_o), 128'(pend == 0));
      chk(res_valid_o == (res_q.size() > 0), rv_tag, 128'(res_valid_o), 128'(res_q.size() > 0));
      if (res_q.size() > 0 && res_valid_o) begin
        chk(res_err_o == res_q[0][DW], "R7", 128'(res_err_o), 128'(res_q[0][DW]));
        chk(res_data_o == res_q[0][DW-1:0], "R6", 128'(res_data_o), 128'(res_q[0][DW-1:0]));
      end
      acc = req_valid_i && exp_ready;
      rsp = (wb_ack_i || wb_err_i || wb_rty_i) && pend > 0;
      if (res_valid_o && res_ready_i && res_q.size() > 0) void'(res_q.pop_front());
      if (rsp) begin
        res_q.push_back({wb_err_i || wb_rty_i, wb_dat_i});
        void'(slave_q.pop_front());
        pend--;
      end
      if (acc) begin
        slave_q.push_back(req_addr_i);
        pend++;
      end
      acc_last = acc;
    end
  endtask

  bit acc_last = 0;

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 during reset
    chk(idle_o && !wb_cyc_o && !wb_stb_o && !res_valid_o, "R1", 128'({idle_o, wb_cyc_o, res_valid_o}), 128'(3'b100));
    rst_ni = 1;
    @(negedge clk_i);
    chk(idle_o && !wb_cyc_o && !res_valid_o, "R1", 128'({idle_o, wb_cyc_o, res_valid_o}), 128'(3'b100));
    // fill to the limit with the result port blocked (R4), then drain
    run_phase(40, 100, 0, 80, 0, 0, 0);
    run_phase(40, 100, 0, 80, 0, 100, 0);
    // heavy stall (R3)
    run_phase(300, 80, 60, 50, 20, 60, 0);
    // error and retry mix (R7)
    run_phase(300, 70, 20, 60, 60, 70, 0);
    // back to back, fast slave
    run_phase(400, 100, 0, 100, 10, 100, 0);
    // stray responses while idle (R10)
    run_phase(60, 0, 0, 100, 0, 100, 0);
    rv_tag = "R10";
    run_phase(200, 0, 0, 100, 0, 100, 1);
    rv_tag = "R8";
    // mixed random
    run_phase(800, 60, 30, 40, 25, 50, 1);
    run_phase(100, 0, 0, 100, 0, 100, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule